// File: doc/BRIEF.md
# Real-Mode Interrupt Dispatch Sequencer

This block takes pending events and turns each one into the bus traffic that a real-mode processor core performs when it enters a handler. The events are an exception with its own vector, a single-step trap, a non-maskable interrupt and a maskable interrupt. It also runs the matching return sequence. The block keeps an interrupt-table register made of a linear base address and a byte limit, and a load command can rewrite it. For each event it forms the address of the table entry, checks that entry against the limit, and then issues stack pushes and table reads on a single request/acknowledge memory port.

Entry saves the flags word, then the code segment, then the instruction pointer on the stack. It then reads the handler's far pointer from the table and reports the new code segment, instruction pointer, stack pointer and flags on a one-cycle `done` pulse. The reported flags have the interrupt-enable and trap bits cleared. The return command pops the three words back in reverse order. The core's register values are sampled when an event or return is accepted, and the core copies the results back when `done` is high. Instruction decode, the memory itself and the handler code are outside the block.

Top module: `irq_dispatch_seq`

## Requirements
- R1: After reset the table base is 0 and the limit is 3FFh, no memory request is active, `busy` is low and the non-maskable interrupt is not blocked.
- R2: A request is accepted only in the idle state, and at most one acknowledge pulses in a cycle. The order of precedence is exception, then single-step trap (vector 1), then non-maskable interrupt (vector 2), then maskable interrupt. The maskable interrupt counts only while `flags_in` bit 9 (interrupt enable) is 1. A return is accepted only when no event is accepted in that cycle.
- R3: Entry writes three words at stack addresses SS×16 + (SP−2), SS×16 + (SP−4) and SS×16 + (SP−6). The SP arithmetic wraps at 16 bits, and a carry out of the 20-bit sum is kept in address bit 20.
- R4: The three pushed words are, in order, the flags with bit 15 forced to 0 (bits 14..0 unchanged), the code segment, and the instruction pointer.
- R5: After the pushes, the new instruction pointer is read from base + 4×vector and the new code segment from base + 4×vector + 2.
- R6: The entry of vector v is used when 4v+3 ≤ limit. Otherwise vector 8 is dispatched in its place, and `vec_o` reports 8.
- R7: A pulse on `tbl_we` loads `tbl_base_in` and `tbl_limit_in`, and every later address and limit check uses the new values.
- R8: At `done` after entry, `flags_o` equals the sampled flags with bits 15, 9 and 8 cleared, and `sp_o` equals SP−6.
- R9: Once a non-maskable interrupt is accepted, further non-maskable requests are not acknowledged until a return sequence completes.
- R10: The return reads the instruction pointer at SS×16+SP, the code segment at SS×16+SP+2 and the flags at SS×16+SP+4. It reports `sp_o` = SP+6 and `flags_o` with bit 15 cleared, and it writes nothing.
- R11: While a memory request waits for `mem_ack`, the address, write enable and write data stay stable and the sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception pending |
| exc_vec | input | 8 | Exception vector |
| step_req | input | 1 | Single-step trap pending |
| nmi_req | input | 1 | Non-maskable interrupt pending |
| intr_req | input | 1 | Maskable interrupt pending |
| intr_vec | input | 8 | Maskable interrupt vector |
| iret_req | input | 1 | Return-from-handler command |
| tbl_we | input | 1 | Load the interrupt-table register |
| tbl_base_in | input | ADDR_W | New table base |
| tbl_limit_in | input | LIM_W | New table limit |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| flags_in | input | 16 | Current flags |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Linear address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completes this cycle |
| exc_ack | output | 1 | Exception accepted |
| step_ack | output | 1 | Single-step trap accepted |
| nmi_ack | output | 1 | Non-maskable interrupt accepted |
| intr_ack | output | 1 | Maskable interrupt accepted |
| iret_ack | output | 1 | Return accepted |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Results valid this cycle |
| nmi_blocked | output | 1 | Non-maskable interrupts masked |
| vec_o | output | 8 | Vector actually dispatched |
| cs_o | output | 16 | New code segment |
| ip_o | output | 16 | New instruction pointer |
| flags_o | output | 16 | New flags |
| sp_o | output | 16 | New stack pointer |

## Verification
Arbitration is where several functions land in the same cycle. The bench raises every event line at once, then drops them one at a time, so that each lower-ranked source can be seen winning only when those above it are absent. The result is judged by the acknowledge pattern and by the vector the sequence dispatches. The same approach puts a non-maskable request together with a maskable one while the non-maskable source is blocked, and puts a return command together with an enabled maskable interrupt. In each case the second source must win. The limit check and the vector-8 substitution fall in the same acceptance cycle, so a vector sweep across the boundary of a reduced limit, run with varying memory wait states, checks the substituted vector, the table addresses and every pushed word.

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq #(
  parameter int ADDR_W = 24,
  parameter int LIM_W  = 16,
  parameter logic [LIM_W-1:0] RST_LIMIT = 16'h03FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [7:0]        exc_vec,
  input  logic              step_req,
  input  logic              nmi_req,
  input  logic              intr_req,
  input  logic [7:0]        intr_vec,
  input  logic              iret_req,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_base_in,
  input  logic [LIM_W-1:0]  tbl_limit_in,
  input  logic [15:0]       cs_in,
  input  logic [15:0]       ip_in,
  input  logic [15:0]       flags_in,
  input  logic [15:0]       ss_in,
  input  logic [15:0]       sp_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              exc_ack,
  output logic              step_ack,
  output logic              nmi_ack,
  output logic              intr_ack,
  output logic              iret_ack,
  output logic              busy,
  output logic              done,
  output logic              nmi_blocked,
  output logic [7:0]        vec_o,
  output logic [15:0]       cs_o,
  output logic [15:0]       ip_o,
  output logic [15:0]       flags_o,
  output logic [15:0]       sp_o
);
  localparam int IF_BIT = 9;
  localparam int TF_BIT = 8;
  localparam logic [7:0] VEC_STEP  = 8'd1;
  localparam logic [7:0] VEC_NMI   = 8'd2;
  localparam logic [7:0] VEC_LIMIT = 8'd8;

  typedef enum logic [3:0] {
    S_IDLE, S_PF, S_PC, S_PI, S_FI, S_FC, S_RI, S_RC, S_RF, S_DONE
  } state_t;

  state_t            state;
  logic [ADDR_W-1:0] tbl_base;
  logic [LIM_W-1:0]  tbl_lim;
  logic [15:0]       cs_r, ip_r, fl_r, ss_r, sp_r;
  logic [7:0]        vec_r;

  wire idle    = (state == S_IDLE);
  wire nmi_ok  = nmi_req && !nmi_blocked;
  wire intr_ok = intr_req && flags_in[IF_BIT];

  assign exc_ack  = idle && exc_req;
  assign step_ack = idle && !exc_req && step_req;
  assign nmi_ack  = idle && !exc_req && !step_req && nmi_ok;
  assign intr_ack = idle && !exc_req && !step_req && !nmi_ok && intr_ok;
  assign iret_ack = idle && !exc_req && !step_req && !nmi_ok && !intr_ok && iret_req;
  wire take_ev = exc_ack || step_ack || nmi_ack || intr_ack;

  wire [7:0] ev_vec = exc_req  ? exc_vec  :
                      step_req ? VEC_STEP :
                      nmi_ok   ? VEC_NMI  : intr_vec;
  wire [LIM_W:0] ent_end = (LIM_W+1)'({ev_vec, 2'b11});
  wire           fits    = ent_end <= {1'b0, tbl_lim};
  wire [7:0]     sel_vec = fits ? ev_vec : VEC_LIMIT;

  wire push_st = (state == S_PF) || (state == S_PC) || (state == S_PI);
  wire pop_st  = (state == S_RI) || (state == S_RC) || (state == S_RF);
  wire tbl_st  = (state == S_FI) || (state == S_FC);

  wire [15:0]       stk_off  = push_st ? sp_r - 16'd2 : sp_r;
  wire [ADDR_W-1:0] stk_addr = ADDR_W'({ss_r, 4'b0000}) + ADDR_W'(stk_off);
  wire [ADDR_W-1:0] tbl_addr = tbl_base + ADDR_W'({vec_r, 2'b00}) +
                               ((state == S_FC) ? ADDR_W'(2) : ADDR_W'(0));

  assign mem_req  = push_st || pop_st || tbl_st;
  assign mem_we   = push_st;
  assign mem_addr = tbl_st ? tbl_addr : stk_addr;
  assign busy     = !idle;
  assign done     = (state == S_DONE);

  always_comb begin
    case (state)
      S_PF:    mem_wdata = {1'b0, fl_r[14:0]};
      S_PC:    mem_wdata = cs_r;
      S_PI:    mem_wdata = ip_r;
      default: mem_wdata = '0;
    endcase
  end

  wire [15:0] entry_flags = fl_r & ~(16'h8000 | (16'h1 << IF_BIT) | (16'h1 << TF_BIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tbl_base    <= '0;
      tbl_lim     <= RST_LIMIT;
      nmi_blocked <= 1'b0;
      cs_r <= '0; ip_r <= '0; fl_r <= '0; ss_r <= '0; sp_r <= '0;
      vec_r <= '0;
      vec_o <= '0; cs_o <= '0; ip_o <= '0; flags_o <= '0; sp_o <= '0;
    end else begin
      if (tbl_we) begin
        tbl_base <= tbl_base_in;
        tbl_lim  <= tbl_limit_in;
      end
      case (state)
        S_IDLE: begin
          if (take_ev || iret_ack) begin
            cs_r <= cs_in; ip_r <= ip_in; fl_r <= flags_in;
            ss_r <= ss_in; sp_r <= sp_in;
          end
          if (take_ev) begin
            vec_r <= sel_vec;
            state <= S_PF;
            if (nmi_ack) nmi_blocked <= 1'b1;
          end else if (iret_ack) begin
            state <= S_RI;
          end
        end
        S_PF: if (mem_ack) begin sp_r <= sp_r - 16'd2; state <= S_PC; end
        S_PC: if (mem_ack) begin sp_r <= sp_r - 16'd2; state <= S_PI; end
        S_PI: if (mem_ack) begin sp_r <= sp_r - 16'd2; state <= S_FI; end
        S_FI: if (mem_ack) begin ip_o <= mem_rdata; state <= S_FC; end
        S_FC: if (mem_ack) begin
          cs_o    <= mem_rdata;
          flags_o <= entry_flags;
          sp_o    <= sp_r;
          vec_o   <= vec_r;
          state   <= S_DONE;
        end
        S_RI: if (mem_ack) begin ip_o <= mem_rdata; sp_r <= sp_r + 16'd2; state <= S_RC; end
        S_RC: if (mem_ack) begin cs_o <= mem_rdata; sp_r <= sp_r + 16'd2; state <= S_RF; end
        S_RF: if (mem_ack) begin
          flags_o     <= {1'b0, mem_rdata[14:0]};
          sp_o        <= sp_r + 16'd2;
          nmi_blocked <= 1'b0;
          state       <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_dispatch_seq_chk.sv
module irq_dispatch_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_req,
  input logic              step_req,
  input logic              nmi_req,
  input logic [15:0]       flags_in,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              exc_ack,
  input logic              step_ack,
  input logic              nmi_ack,
  input logic              intr_ack,
  input logic              iret_ack,
  input logic              busy,
  input logic              done,
  input logic              nmi_blocked,
  input logic [15:0]       flags_o
);
  assert_ack_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_ack, step_ack, nmi_ack, intr_ack, iret_ack}));

  assert_intr_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack |-> flags_in[9] && !exc_req && !step_req && !(nmi_req && !nmi_blocked));

  assert_no_ack_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(exc_ack || step_ack || nmi_ack || intr_ack || iret_ack));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_nmi_sets_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |=> nmi_blocked);

  assert_nmi_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_blocked |-> !nmi_ack);

  assert_flags_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flags_o[15]);
endmodule

bind irq_dispatch_seq irq_dispatch_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .step_req(step_req),
  .nmi_req(nmi_req), .flags_in(flags_in), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .exc_ack(exc_ack), .step_ack(step_ack), .nmi_ack(nmi_ack),
  .intr_ack(intr_ack), .iret_ack(iret_ack), .busy(busy), .done(done),
  .nmi_blocked(nmi_blocked), .flags_o(flags_o)
);

// File: tb/tb_irq_dispatch_seq.sv
module tb_irq_dispatch_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        exc_req, step_req, nmi_req, intr_req, iret_req, tbl_we;
  logic [7:0]  exc_vec, intr_vec;
  logic [23:0] tbl_base_in;
  logic [15:0] tbl_limit_in;
  logic [15:0] cs_in, ip_in, flags_in, ss_in, sp_in;
  logic        mem_req, mem_we, mem_ack;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        exc_ack, step_ack, nmi_ack, intr_ack, iret_ack;
  logic        busy, done, nmi_blocked;
  logic [7:0]  vec_o;
  logic [15:0] cs_o, ip_o, flags_o, sp_o;

  irq_dispatch_seq dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_vec(exc_vec),
    .step_req(step_req), .nmi_req(nmi_req), .intr_req(intr_req),
    .intr_vec(intr_vec), .iret_req(iret_req), .tbl_we(tbl_we),
    .tbl_base_in(tbl_base_in), .tbl_limit_in(tbl_limit_in),
    .cs_in(cs_in), .ip_in(ip_in), .flags_in(flags_in), .ss_in(ss_in),
    .sp_in(sp_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .exc_ack(exc_ack), .step_ack(step_ack), .nmi_ack(nmi_ack),
    .intr_ack(intr_ack), .iret_ack(iret_ack), .busy(busy), .done(done),
    .nmi_blocked(nmi_blocked), .vec_o(vec_o), .cs_o(cs_o), .ip_o(ip_o),
    .flags_o(flags_o), .sp_o(sp_o)
  );

  function automatic logic [15:0] rd(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[23:16], 8'h00};
  endfunction
  assign mem_rdata = rd(mem_addr);

  int gap = 0;
  int scnt = 0;
  int nw = 0;
  logic [23:0] wa [4];
  logic [15:0] wd [4];
  assign mem_ack = mem_req && (scnt >= gap);
  always @(posedge clk) begin
    if (mem_req && !mem_ack) scnt <= scnt + 1; else scnt <= 0;
    if (mem_req && mem_ack && mem_we && nw < 4) begin
      wa[nw] = mem_addr; wd[nw] = mem_wdata; nw = nw + 1;
    end
  end

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [23:0] tb_base = 24'h0;
  logic [15:0] tb_lim  = 16'h03FF;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire(input logic e, s, n, i, r, input logic [7:0] v, output logic [4:0] acks);
    @(negedge clk);
    exc_req = e; step_req = s; nmi_req = n; intr_req = i; iret_req = r;
    exc_vec = v; intr_vec = v;
    #1;
    acks = {exc_ack, step_ack, nmi_ack, intr_ack, iret_ack};
    nw = 0;
    @(negedge clk);
    exc_req = 0; step_req = 0; nmi_req = 0; intr_req = 0; iret_req = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 60; k++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic entry(input string tag, input logic e, s, n, i, input logic [7:0] v,
                       input logic [4:0] exp_ack, input logic [7:0] raw);
    logic [4:0] acks;
    logic [7:0] vv;
    logic [23:0] sbase, ent;
    bit ok;
    fire(e, s, n, i, 1'b0, v, acks);
    chk({"R2 ack ", tag}, acks, exp_ack);
    if (exp_ack == 0) begin
      chk({"R2 idle ", tag}, busy, 0);
      return;
    end
    wait_done(ok);
    chk({"R11 done ", tag}, ok, 1);
    if (!ok) return;
    vv = ({22'h0, raw, 2'b11} <= {16'h0, tb_lim}) ? raw : 8'd8;
    chk({"R6 vec ", tag}, vec_o, vv);
    chk({"R3 nwrites ", tag}, nw, 3);
    sbase = {4'h0, ss_in, 4'h0};
    chk({"R3 addr0 ", tag}, wa[0], sbase + {8'h0, 16'(sp_in - 16'd2)});
    chk({"R3 addr1 ", tag}, wa[1], sbase + {8'h0, 16'(sp_in - 16'd4)});
    chk({"R3 addr2 ", tag}, wa[2], sbase + {8'h0, 16'(sp_in - 16'd6)});
    chk({"R4 flags ", tag}, wd[0], flags_in & 16'h7FFF);
    chk({"R4 cs ", tag}, wd[1], cs_in);
    chk({"R4 ip ", tag}, wd[2], ip_in);
    ent = tb_base + {14'h0, vv, 2'b00};
    chk({"R5 ip_o ", tag}, ip_o, rd(ent));
    chk({"R5 cs_o ", tag}, cs_o, rd(ent + 24'd2));
    chk({"R8 flags_o ", tag}, flags_o, flags_in & 16'h7CFF);
    chk({"R8 sp_o ", tag}, sp_o, 16'(sp_in - 16'd6));
  endtask

  task automatic do_iret(input string tag);
    logic [4:0] acks;
    logic [23:0] sbase;
    bit ok;
    fire(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0, acks);
    chk({"R2 iret ack ", tag}, acks, 5'b00001);
    wait_done(ok);
    chk({"R10 done ", tag}, ok, 1);
    sbase = {4'h0, ss_in, 4'h0};
    chk({"R10 ip_o ", tag}, ip_o, rd(sbase + {8'h0, sp_in}));
    chk({"R10 cs_o ", tag}, cs_o, rd(sbase + {8'h0, 16'(sp_in + 16'd2)}));
    chk({"R10 flags_o ", tag}, flags_o, rd(sbase + {8'h0, 16'(sp_in + 16'd4)}) & 16'h7FFF);
    chk({"R10 sp_o ", tag}, sp_o, 16'(sp_in + 16'd6));
    chk({"R10 nowrite ", tag}, nw, 0);
    @(negedge clk);
    chk({"R9 unblock ", tag}, nmi_blocked, 0);
  endtask

  initial begin
    rst_n = 0; exc_req = 0; step_req = 0; nmi_req = 0; intr_req = 0; iret_req = 0;
    tbl_we = 0; exc_vec = 0; intr_vec = 0; tbl_base_in = 0; tbl_limit_in = 0;
    cs_in = 16'h1234; ip_in = 16'h5678; flags_in = 16'hF3FF;
    ss_in = 16'h2000; sp_in = 16'h0100;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 busy", busy, 0);
    chk("R1 nmi_blocked", nmi_blocked, 0);

    // R1 default table: every vector fits under 3FFh
    entry("R1 v255", 1, 0, 0, 0, 8'd255, 5'b10000, 8'd255);
    entry("R1 v0",   1, 0, 0, 0, 8'd0,   5'b10000, 8'd0);
    entry("exc v100", 1, 0, 0, 0, 8'd100, 5'b10000, 8'd100);

    // R7 load a smaller table, R6 boundary sweep, R11 wait states
    @(negedge clk);
    tbl_we = 1; tbl_base_in = 24'h012340; tbl_limit_in = 16'h007F;
    @(negedge clk);
    tbl_we = 0; tb_base = 24'h012340; tb_lim = 16'h007F;
    for (int v = 0; v < 64; v++) begin
      gap = v % 3;
      sp_in = 16'h0100 + 16'(v * 8);
      entry("R7 R6 sweep", 0, 0, 0, 1, 8'(v), 5'b00010, 8'(v));
    end
    gap = 1;
    sp_in = 16'h0100;

    // R2 precedence
    entry("R2 all", 1, 1, 1, 1, 8'd20, 5'b10000, 8'd20);
    entry("R2 step", 0, 1, 1, 1, 8'd20, 5'b01000, 8'd1);
    entry("R2 nmi", 0, 0, 1, 1, 8'd20, 5'b00100, 8'd2);
    chk("R9 blocked", nmi_blocked, 1);
    entry("R9 intr over blocked nmi", 0, 0, 1, 1, 8'd21, 5'b00010, 8'd21);
    entry("R9 nmi ignored", 0, 0, 1, 0, 8'd0, 5'b00000, 8'd0);
    chk("R9 still blocked", nmi_blocked, 1);
    sp_in = 16'h0200;
    do_iret("R10 first");
    entry("R9 nmi again", 0, 0, 1, 0, 8'd0, 5'b00100, 8'd2);
    do_iret("R10 second");

    flags_in = 16'h71FF;
    entry("R2 intr masked", 0, 0, 0, 1, 8'd5, 5'b00000, 8'd5);
    flags_in = 16'hF3FF;
    begin
      logic [4:0] acks;
      fire(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd6, acks);
      chk("R2 intr beats iret", acks, 5'b00010);
      for (int k = 0; k < 40 && busy; k++) @(negedge clk);
    end

    // R3 stack carry into bit 20, and SP wrap
    gap = 0;
    ss_in = 16'hFFFF; sp_in = 16'h0020;
    entry("R3 carry", 1, 0, 0, 0, 8'd3, 5'b10000, 8'd3);
    ss_in = 16'h0040; sp_in = 16'h0002;
    entry("R3 wrap", 1, 0, 0, 0, 8'd4, 5'b10000, 8'd4);
    ss_in = 16'hFFFF; sp_in = 16'hFFFC;
    do_iret("R10 carry");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule